// File: doc/BRIEF.md
# Multi-Channel SAR Conversion Sequencer

This block drives a successive-approximation converter across up to eight input channels. A channel-enable mask picks which inputs take part. A start strobe loads the internal channel pointer with a chosen channel and begins work at the first enabled channel found at or after it, moving upward and wrapping from the top channel back to channel 0. For each conversion the block registers the channel number on a select output and holds two sampling cycles. It then runs a binary search, most significant bit first. A trial code goes out to an external DAC/comparator pair, and the comparator answer decides whether each trial bit stays set.

Results land in a per-channel pair of 8-bit registers, read through a registered read port. A 10-bit result is split across the pair. An 8-bit result fits in the first register of the pair alone. Three sequencing modes are selectable. Step mode converts one channel per command. One-pass mode converts every enabled channel once. Loop mode cycles until it is reconfigured. A two-bit status word reports busy and done, and an active-low interrupt follows the done bit until the host reads the status.

Top module: `scan_sar_sequencer`

## Requirements
- R1: Only channels whose bit is set in `chan_mask` are converted; disabled channels are skipped without costing any cycles.
- R2: `start` loads the pointer with `start_ch`; the first conversion is on the lowest-offset enabled channel at or above `start_ch`, later ones go upward, and the pointer wraps from channel 7 to channel 0.
- R3: With `cfg_mode` 0 (or 3), one channel is converted per `start` or `step_cmd`; the block then goes idle with the pointer just past that channel. `step_cmd` acts only in this mode and only while idle.
- R4: With `cfg_mode` 1, every enabled channel is converted exactly once, then the block goes idle and sets done.
- R5: With `cfg_mode` 2, conversions repeat through the enabled channels; done is set each time all of them have been converted; after a switch to mode 0 the block stops once the current conversion ends.
- R6: From the clock edge that accepts `start` or `step_cmd` to the edge that sets done is 14 cycles at 10-bit resolution and 12 cycles at 8-bit resolution; back-to-back conversions are spaced by the same count.
- R7: The result equals the binary search on `trial_code`: each trial sets the next lower bit, and the bit is kept when `cmp_hi` is 1 (input at or above the trial code).
- R8: At 10-bit resolution, address `{ch,0}` holds `{6'b0, result[9:8]}` and address `{ch,1}` holds `result[7:0]`; `rd_data` shows the register one cycle after `rd_addr` is applied.
- R9: At 8-bit resolution (`cfg_res10` = 0), the result is written to address `{ch,0}` and `{ch,1}` keeps its old value.
- R10: `status[0]` is busy (a conversion run is in progress) and `status[1]` is done; `irq_n` is 0 exactly while done is 1.
- R11: A `stat_rd` pulse clears done and releases `irq_n` on the next edge; if done is set on that same edge, done stays 1.
- R12: With `chan_mask` all zero, `start` launches no conversion and busy stays 0.
- R13: After reset: status 0, `irq_n` 1, `trial_code` 0, `chan_sel` 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Converter clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 2 | 0/3 step, 1 one-pass, 2 loop |
| cfg_res10 | input | 1 | 1 = 10-bit, 0 = 8-bit conversions |
| chan_mask | input | 8 | Channel enable mask, bit n enables channel n |
| start | input | 1 | Load pointer from `start_ch` and begin |
| start_ch | input | 3 | Starting channel |
| step_cmd | input | 1 | Convert next channel in step mode |
| cmp_hi | input | 1 | Comparator: 1 when input is at or above `trial_code` |
| trial_code | output | 10 | Trial code to the external DAC |
| chan_sel | output | 3 | Channel being converted |
| stat_rd | input | 1 | Status read strobe |
| status | output | 2 | {done, busy} |
| irq_n | output | 1 | Active-low completion interrupt |
| rd_addr | input | 4 | Result register address {channel, half} |
| rd_data | output | 8 | Result register contents, one cycle after address |

## Verification
The host's status read and the sequencer's own done update can land on the same clock edge. The bench provokes this by timing `stat_rd` to sit exactly on the fourteenth edge after a step-mode start, the edge where the conversion completes. The collision is judged correct when done stays set and `irq_n` stays low after that edge, and a later read with no completion pending then clears both.

// File: rtl/scan_pkg.sv
package scan_pkg;
  typedef enum logic [1:0] {
    MODE_STEP     = 2'd0,
    MODE_PASS     = 2'd1,
    MODE_LOOP     = 2'd2,
    MODE_STEP_ALT = 2'd3
  } scan_mode_t;

  typedef enum logic [1:0] {SEQ_IDLE, SEQ_ADV, SEQ_RUN} seq_st_t;

  typedef enum logic [1:0] {SAR_IDLE, SAR_SAMP, SAR_BIT, SAR_STORE} sar_st_t;
endpackage

// File: rtl/chan_picker.sv
// Circular search: nearest enabled channel at or above 'from'. NCH power of two.
module chan_picker #(
  parameter int NCH = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic [NCH-1:0] mask,
  input  logic [CW-1:0]  from,
  output logic           found,
  output logic [CW-1:0]  ch
);
  always_comb begin
    found = 1'b0;
    ch    = from;
    for (int i = NCH - 1; i >= 0; i--) begin
      logic [CW-1:0] idx;
      idx = CW'(from + CW'(i));
      if (mask[idx]) begin
        found = 1'b1;
        ch    = idx;
      end
    end
  end
endmodule

// File: rtl/sar_core.sv
module sar_core import scan_pkg::*; #(
  parameter int RES_HI   = 10,
  parameter int RES_LO   = 8,
  parameter int SAMP_CYC = 2,
  localparam int BW = $clog2(RES_HI),
  localparam int SW = (SAMP_CYC > 1) ? $clog2(SAMP_CYC) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              abort,
  input  logic              wide_in,
  input  logic              cmp_hi,
  output logic [RES_HI-1:0] trial,
  output logic [RES_HI-1:0] result,
  output logic              wide,
  output logic              conv_done
);
  localparam logic [RES_HI-1:0] ONE = RES_HI'(1);

  sar_st_t           st_q;
  logic [SW-1:0]     cnt_q;
  logic [BW-1:0]     bit_q;
  logic [RES_HI-1:0] acc_q, trial_q, keep;
  logic              wide_q;

  assign keep = cmp_hi ? trial_q : acc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= SAR_IDLE;
      cnt_q   <= '0;
      bit_q   <= '0;
      acc_q   <= '0;
      trial_q <= '0;
      wide_q  <= 1'b0;
    end else if (abort) begin
      st_q    <= SAR_IDLE;
      trial_q <= '0;
    end else begin
      unique case (st_q)
        SAR_IDLE: if (go) begin
          st_q    <= SAR_SAMP;
          cnt_q   <= '0;
          acc_q   <= '0;
          trial_q <= '0;
          wide_q  <= wide_in;
        end
        SAR_SAMP: begin
          if (cnt_q == SW'(SAMP_CYC - 1)) begin
            st_q    <= SAR_BIT;
            bit_q   <= wide_q ? BW'(RES_HI - 1) : BW'(RES_LO - 1);
            trial_q <= ONE << (wide_q ? BW'(RES_HI - 1) : BW'(RES_LO - 1));
          end else begin
            cnt_q <= cnt_q + 1'b1;
          end
        end
        SAR_BIT: begin
          acc_q <= keep;
          if (bit_q == '0) begin
            st_q    <= SAR_STORE;
            trial_q <= keep;
          end else begin
            bit_q   <= bit_q - 1'b1;
            trial_q <= keep | (ONE << (bit_q - 1'b1));
          end
        end
        default: st_q <= SAR_IDLE;
      endcase
    end
  end

  assign trial     = trial_q;
  assign result    = acc_q;
  assign wide      = wide_q;
  assign conv_done = (st_q == SAR_STORE);

  // R7
  trial_one_ahead_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SAR_BIT) |-> ($countones(trial_q ^ acc_q) == 1));

  // R6
  store_after_bits_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SAR_STORE) |-> ($past(st_q) == SAR_BIT && $past(bit_q) == '0));
endmodule

// File: rtl/result_bank.sv
module result_bank #(
  parameter int NCH    = 8,
  parameter int DW     = 8,
  parameter int RES_HI = 10,
  parameter int RES_LO = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              we,
  input  logic              wide,
  input  logic [CW-1:0]     wch,
  input  logic [RES_HI-1:0] res,
  input  logic [CW:0]       rd_addr,
  output logic [DW-1:0]     rd_data
);
  logic [DW-1:0] hi_mem [NCH];
  logic [DW-1:0] lo_mem [NCH];
  logic [DW-1:0] hi_q, lo_q;
  logic          half_q;
  logic [DW-1:0] hi_wdata;

  assign hi_wdata = wide ? DW'(res[RES_HI-1:DW]) : DW'(res[RES_LO-1:0]);

  always_ff @(posedge clk) begin
    if (we) hi_mem[wch] <= hi_wdata;
  end

  always_ff @(posedge clk) begin
    if (we && wide) lo_mem[wch] <= res[DW-1:0];
  end

  always_ff @(posedge clk) begin
    hi_q   <= hi_mem[rd_addr[CW:1]];
    lo_q   <= lo_mem[rd_addr[CW:1]];
    half_q <= rd_addr[0];
  end

  assign rd_data = half_q ? lo_q : hi_q;
endmodule

// File: rtl/scan_sar_sequencer.sv
module scan_sar_sequencer import scan_pkg::*; #(
  parameter int NCH    = 8,
  parameter int RES_HI = 10,
  parameter int RES_LO = 8,
  parameter int DW     = 8,
  localparam int CW = $clog2(NCH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        cfg_mode,
  input  logic              cfg_res10,
  input  logic [NCH-1:0]    chan_mask,
  input  logic              start,
  input  logic [CW-1:0]     start_ch,
  input  logic              step_cmd,
  input  logic              cmp_hi,
  output logic [RES_HI-1:0] trial_code,
  output logic [CW-1:0]     chan_sel,
  input  logic              stat_rd,
  output logic [1:0]        status,
  output logic              irq_n,
  input  logic [CW:0]       rd_addr,
  output logic [DW-1:0]     rd_data
);
  seq_st_t           st_q;
  logic [CW-1:0]     ptr_q, chan_q, pick_from, pick_ch;
  logic [NCH-1:0]    covered_q, covered_n;
  logic              done_q, irq_n_q, done_n, set_done;
  logic              pick_ok, sar_go, conv_done, res_wide;
  logic              is_step, is_loop, step_ok, pass_full;
  logic [RES_HI-1:0] sar_res;

  assign is_step   = (cfg_mode == MODE_STEP) || (cfg_mode == MODE_STEP_ALT);
  assign is_loop   = (cfg_mode == MODE_LOOP);
  assign pick_from = start ? start_ch : ptr_q;
  assign step_ok   = step_cmd && is_step && (st_q == SEQ_IDLE);
  assign sar_go    = (st_q == SEQ_ADV) && pick_ok && !start;
  assign covered_n = covered_q | (NCH'(1) << chan_q);
  assign pass_full = ((chan_mask & ~covered_n) == '0);
  assign set_done  = conv_done && !start && (is_step || pass_full);
  assign done_n    = set_done ? 1'b1 : (stat_rd ? 1'b0 : done_q);

  chan_picker #(.NCH(NCH)) u_pick (
    .mask (chan_mask),
    .from (pick_from),
    .found(pick_ok),
    .ch   (pick_ch)
  );

  sar_core #(.RES_HI(RES_HI), .RES_LO(RES_LO), .SAMP_CYC(2)) u_sar (
    .clk      (clk),
    .rst      (rst),
    .go       (sar_go),
    .abort    (start),
    .wide_in  (cfg_res10),
    .cmp_hi   (cmp_hi),
    .trial    (trial_code),
    .result   (sar_res),
    .wide     (res_wide),
    .conv_done(conv_done)
  );

  result_bank #(.NCH(NCH), .DW(DW), .RES_HI(RES_HI), .RES_LO(RES_LO)) u_bank (
    .clk    (clk),
    .we     (conv_done),
    .wide   (res_wide),
    .wch    (chan_q),
    .res    (sar_res),
    .rd_addr(rd_addr),
    .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q      <= SEQ_IDLE;
      ptr_q     <= '0;
      chan_q    <= '0;
      covered_q <= '0;
      done_q    <= 1'b0;
      irq_n_q   <= 1'b1;
    end else begin
      done_q  <= done_n;
      irq_n_q <= ~done_n;
      if (start) begin
        ptr_q     <= start_ch;
        covered_q <= '0;
        st_q      <= pick_ok ? SEQ_ADV : SEQ_IDLE;
      end else begin
        unique case (st_q)
          SEQ_IDLE: if (step_ok && pick_ok) st_q <= SEQ_ADV;
          SEQ_ADV: begin
            if (pick_ok) begin
              chan_q <= pick_ch;
              ptr_q  <= pick_ch;
              st_q   <= SEQ_RUN;
            end else begin
              st_q <= SEQ_IDLE;
            end
          end
          SEQ_RUN: if (conv_done) begin
            ptr_q <= chan_q + 1'b1;
            if (is_step) begin
              covered_q <= '0;
              st_q      <= SEQ_IDLE;
            end else if (pass_full) begin
              covered_q <= '0;
              st_q      <= is_loop ? SEQ_ADV : SEQ_IDLE;
            end else begin
              covered_q <= covered_n;
              st_q      <= SEQ_ADV;
            end
          end
          default: st_q <= SEQ_IDLE;
        endcase
      end
    end
  end

  assign chan_sel = chan_q;
  assign status   = {done_q, (st_q != SEQ_IDLE)};
  assign irq_n    = irq_n_q;

  // R1
  go_enabled_chk: assert property (@(posedge clk) disable iff (rst)
    sar_go |-> chan_mask[pick_ch]);

  // R12
  zero_mask_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (start && chan_mask == '0) |=> (st_q == SEQ_IDLE));

  // R3
  step_idle_chk: assert property (@(posedge clk) disable iff (rst)
    (conv_done && !start && is_step) |=> (st_q == SEQ_IDLE && done_q));

  // R11
  rd_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_rd && !set_done) |=> !done_q);

  // R10
  irq_follows_done_chk: assert property (@(posedge clk) disable iff (rst)
    irq_n_q != done_q);
endmodule

// File: tb/test_scan_sar_sequencer.sv
module test_scan_sar_sequencer;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] cfg_mode = 2'd0;
  logic       cfg_res10 = 1'b1;
  logic [7:0] chan_mask = 8'hFF;
  logic       start = 1'b0;
  logic [2:0] start_ch = 3'd0;
  logic       step_cmd = 1'b0;
  logic       cmp_hi;
  logic [9:0] trial_code;
  logic [2:0] chan_sel;
  logic       stat_rd = 1'b0;
  logic [1:0] status;
  logic       irq_n;
  logic [3:0] rd_addr = 4'd0;
  logic [7:0] rd_data;

  logic [9:0] ana [8];
  int nchk = 0, nfail = 0;
  logic [2:0] seen [64];
  int nseen = 0;
  logic [9:0] prev_trial = '0;

  always #10 clk = ~clk;

  assign cmp_hi = (ana[chan_sel] >= trial_code);

  scan_sar_sequencer i_scan_sar_sequencer (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .cfg_res10(cfg_res10),
    .chan_mask(chan_mask), .start(start), .start_ch(start_ch),
    .step_cmd(step_cmd), .cmp_hi(cmp_hi), .trial_code(trial_code),
    .chan_sel(chan_sel), .stat_rd(stat_rd), .status(status), .irq_n(irq_n),
    .rd_addr(rd_addr), .rd_data(rd_data)
  );

  // conversion log: first trial after the sampling cycles marks a new conversion
  always @(negedge clk) begin
    if (!rst && status[0] && prev_trial == '0 && trial_code != '0 && nseen < 64) begin
      seen[nseen] = chan_sel;
      nseen++;
    end
    prev_trial = trial_code;
  end

  task automatic check(input string req, input int act, input int exp);
    nchk++;
    if (act != exp) begin
      nfail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic kick(input logic [2:0] ch);
    @(negedge clk); start = 1'b1; start_ch = ch;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic step_once();
    @(negedge clk); step_cmd = 1'b1;
    @(negedge clk); step_cmd = 1'b0;
  endtask

  task automatic clear_status();
    @(negedge clk); stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
  endtask

  task automatic wait_done(output int n);
    n = 0;
    while (!status[1] && n < 2000) begin
      @(negedge clk); n++;
    end
  endtask

  task automatic read_reg(input logic [2:0] ch, input logic half, output logic [7:0] d);
    @(negedge clk); rd_addr = {ch, half};
    @(negedge clk); d = rd_data;
  endtask

  task automatic t_reset();
    check("R13 status", status, 0);
    check("R13 irq_n", irq_n, 1);
    check("R13 trial_code", trial_code, 0);
    check("R13 chan_sel", chan_sel, 0);
  endtask

  task automatic t_step10();
    int n; logic [7:0] d;
    cfg_mode = 2'd0; cfg_res10 = 1'b1; chan_mask = 8'b1110_1111;
    kick(3'd3);
    check("R10 busy after start", status[0], 1);
    wait_done(n);
    check("R6 10-bit latency", n, 14);
    check("R3 idle after one", status[0], 0);
    check("R10 irq_n low", irq_n, 0);
    read_reg(3'd3, 1'b0, d); check("R8 ch3 first reg", d, 8'h02);
    read_reg(3'd3, 1'b1, d); check("R7 R8 ch3 second reg", d, 8'hA5);
    clear_status();
    check("R11 done cleared", status[1], 0);
    check("R11 irq released", irq_n, 1);
    step_once();
    wait_done(n);
    check("R6 step latency", n, 14);
    check("R1 R3 step skips ch4", seen[nseen-1], 5);
    read_reg(3'd5, 1'b0, d); check("R8 ch5 first reg", d, 8'h01);
    read_reg(3'd5, 1'b1, d); check("R8 ch5 second reg", d, 8'h55);
    clear_status();
  endtask

  task automatic t_pass();
    int n, base; logic [7:0] d;
    cfg_mode = 2'd1; chan_mask = 8'b1010_0110;
    base = nseen;
    kick(3'd6);
    wait_done(n);
    check("R4 R6 pass cycles", n, 56);
    check("R4 pass count", nseen - base, 4);
    check("R2 first ch7", seen[base], 7);
    check("R2 wrap to ch1", seen[base+1], 1);
    check("R2 ascending ch2", seen[base+2], 2);
    check("R1 ch5 last", seen[base+3], 5);
    repeat (40) @(negedge clk);
    check("R4 stays idle", status[0], 0);
    check("R4 no extra conversions", nseen - base, 4);
    read_reg(3'd7, 1'b0, d); check("R7 ch7 full-scale hi", d, 8'h03);
    read_reg(3'd7, 1'b1, d); check("R7 ch7 full-scale lo", d, 8'hFF);
    read_reg(3'd2, 1'b1, d); check("R7 ch2 lo", d, 8'hC7);
    clear_status();
  endtask

  task automatic t_res8();
    int n; logic [7:0] d;
    cfg_mode = 2'd0; cfg_res10 = 1'b1; chan_mask = 8'hFF;
    kick(3'd0); wait_done(n); clear_status();
    read_reg(3'd0, 1'b1, d); check("R8 ch0 lo before", d, 8'h1A);
    cfg_res10 = 1'b0; ana[0] = 10'h0C3;
    kick(3'd0); wait_done(n);
    check("R6 8-bit latency", n, 12);
    read_reg(3'd0, 1'b0, d); check("R9 8-bit in first reg", d, 8'hC3);
    read_reg(3'd0, 1'b1, d); check("R9 second reg kept", d, 8'h1A);
    clear_status();
    cfg_res10 = 1'b1;
  endtask

  task automatic t_loop();
    int n, base, cnt;
    cfg_mode = 2'd2; chan_mask = 8'b0100_0001;
    base = nseen;
    kick(3'd6);
    wait_done(n);
    check("R5 first loop done", n, 28);
    clear_status();
    wait_done(n);
    check("R5 R6 back-to-back period", n, 26);
    check("R5 order 6", seen[base], 6);
    check("R5 order 0", seen[base+1], 0);
    check("R5 order 6 again", seen[base+2], 6);
    check("R5 order 0 again", seen[base+3], 0);
    @(negedge clk); cfg_mode = 2'd0;
    cnt = 0;
    while (status[0] && cnt < 200) begin @(negedge clk); cnt++; end
    check("R5 stops after switch", status[0], 0);
    cnt = nseen;
    repeat (40) @(negedge clk);
    check("R5 no conversions after stop", nseen - cnt, 0);
    clear_status();
  endtask

  task automatic t_zero_mask();
    int base;
    chan_mask = 8'h00; base = nseen;
    kick(3'd2);
    check("R12 busy clear at once", status[0], 0);
    repeat (20) @(negedge clk);
    check("R12 busy still clear", status[0], 0);
    check("R12 no conversion", nseen - base, 0);
    check("R12 no done", status[1], 0);
  endtask

  task automatic t_collide();
    cfg_mode = 2'd0; chan_mask = 8'hFF;
    kick(3'd1);
    repeat (13) @(negedge clk);
    check("R6 not done at 13", status[1], 0);
    stat_rd = 1'b1;
    @(negedge clk); stat_rd = 1'b0;
    check("R11 set wins over read", status[1], 1);
    check("R11 irq held", irq_n, 0);
    clear_status();
    check("R11 later read clears", status[1], 0);
  endtask

  initial begin
    ana[0] = 10'h11A; ana[1] = 10'h2F3; ana[2] = 10'h0C7; ana[3] = 10'h2A5;
    ana[4] = 10'h0F0; ana[5] = 10'h155; ana[6] = 10'h201; ana[7] = 10'h3FF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_step10();
    t_pass();
    t_res8();
    t_loop();
    t_zero_mask();
    t_collide();
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", nchk, nfail);
    $finish;
  end
endmodule